// File: doc/BRIEF.md
# Interrupt Event Queue Writer

This block turns an interrupt trigger into one entry in a circular event queue held in system memory. A trigger names a source. The block looks that source up in a local source table, which gives a queue selector and a 31-bit event payload. It then looks up the selected queue's descriptor. The descriptor gives the queue's base address, its size, its producer index and its generation bit. When the queue accepts entries, the block writes a 32-bit event word at the producer slot through a request/response memory port. On success it advances the index and stores it back into the descriptor.

The top bit of every event word carries the queue's generation bit. That bit flips each time the producer index wraps to zero. A consumer can therefore tell fresh entries from stale ones without a shared read pointer. Software fills both tables and reads them back through a small word-addressed register port. Only one trigger is in flight at a time. The trigger handshake stays low until the memory response has returned. Faults are reported on a one-cycle error pulse that carries a code.

Top module: `evq_writer`

## Requirements
- R1: After reset the block is idle with `trig_ready` high, `mem_req_valid` low and `err_valid` low, and every table word reads back as zero.
- R2: A trigger on a source whose valid bit (source word 0 bit 0) is clear makes no memory request and pulses `err_valid` with `err_code` 1, whatever its mask bit says.
- R3: A trigger on a valid source whose mask bit (source word 0 bit 1) is set makes no memory request, raises no error and leaves the queue's index and generation unchanged.
- R4: A source whose queue selector (source word 0 bits 15:8) is equal to or above the queue count `N_Q` makes no memory request and pulses `err_valid` with `err_code` 2.
- R5: A descriptor whose priority field (descriptor word 4 bits 7:0) is 0xFF marks its queue as switched off. A trigger that reaches it makes no request, pulses `err_code` 3, and leaves the index and generation unchanged. Any other priority value lets the write proceed.
- R6: A descriptor whose enqueue-enable bit (descriptor word 0 bit 0) is clear makes no memory request, raises no error and leaves the index and generation unchanged.
- R7: The 60-bit write address is the queue base plus four times the producer index. The base takes its upper 28 bits from descriptor word 2 bits 27:0 and its lower 32 bits from descriptor word 3, and the addition carries across bit 32.
- R8: The event word has the generation bit at bit 31 and bits 30:0 of source word 1 below it. It is sent big-endian: `mem_wdata[7:0]` carries word bits 31:24 and `mem_wdata[31:24]` carries word bits 7:0.
- R9: After a successful response the producer index (descriptor word 1 bits 21:0) becomes (index + 1) mod 2^(qsize + 10), where qsize is descriptor word 0 bits 7:4. Sizes that exceed the 22-bit index field wrap at 2^22. When the new index is 0, the generation bit (descriptor word 1 bit 31) is inverted.
- R10: A response with `mem_rsp_err` set leaves the index and generation unchanged and pulses `err_valid` with `err_code` 4.
- R11: `trig_ready` is low from the cycle after a trigger is accepted until the block returns to idle. `mem_req_valid`, `mem_addr` and `mem_wdata` hold steady until `mem_req_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_valid | input | 1 | Trigger request |
| trig_src | input | SRC_W | Source number of the trigger |
| trig_ready | output | 1 | High when idle; a trigger is taken when valid and ready are both high |
| cfg_wr | input | 1 | Table write strobe |
| cfg_tbl | input | 1 | Table select: 0 source table, 1 descriptor table |
| cfg_row | input | ROW_W | Row (source or queue number) |
| cfg_word | input | 3 | Word within the row (source 0..1, descriptor 0..4) |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data of the addressed word, combinational |
| mem_req_valid | output | 1 | Memory write request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_addr | output | 60 | Byte address of the entry |
| mem_wdata | output | 32 | Event word, lowest-address byte in bits 7:0 |
| mem_rsp_valid | input | 1 | Write response |
| mem_rsp_err | input | 1 | Write failed |
| err_valid | output | 1 | One-cycle error pulse |
| err_code | output | 3 | 1 invalid source, 2 queue out of range, 3 queue switched off, 4 write failed |

## Verification
The assertions check on every cycle that a pending request and its address and data hold steady until accepted, and that no request is raised while an error is being reported. They also check that a switched-off descriptor never leads to a request, and that each index update stores the engine's index and flips the stored generation exactly when that index is zero. Only the bench's scenarios show the arithmetic results. These are the 60-bit address with its carry, the byte order of the event word, and the wrap point for each queue size. A sweep of more than one full lap of the smallest queue exercises them. The drop and error paths are observed at the ports and through table readback.

// File: rtl/evq_pkg.sv
package evq_pkg;
  localparam int unsigned EVQ_WORD_W   = 32;
  localparam int unsigned EVQ_IDX_W    = 22;
  localparam int unsigned EVQ_HI_W     = 28;
  localparam int unsigned EVQ_ADDR_W   = EVQ_HI_W + EVQ_WORD_W;
  localparam int unsigned EVQ_DATA_W   = EVQ_WORD_W - 1;
  localparam int unsigned EVQ_QSZ_BIAS = 10;
  localparam logic [7:0]  EVQ_PRIO_OFF = 8'hFF;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_SRC  = 3'd1,
    ST_DESC = 3'd2,
    ST_REQ  = 3'd3,
    ST_RSP  = 3'd4
  } evq_state_e;

  typedef enum logic [2:0] {
    EVQ_ERR_NONE      = 3'd0,
    EVQ_ERR_BAD_SRC   = 3'd1,
    EVQ_ERR_BAD_QUEUE = 3'd2,
    EVQ_ERR_QUEUE_OFF = 3'd3,
    EVQ_ERR_WRITE     = 3'd4
  } evq_err_e;

  typedef struct packed {
    logic                  valid;
    logic                  masked;
    logic [7:0]            qsel;
    logic [EVQ_DATA_W-1:0] data;
  } evq_src_t;

  typedef struct packed {
    logic                  enq;
    logic [3:0]            qsize;
    logic                  gen;
    logic [EVQ_IDX_W-1:0]  idx;
    logic [EVQ_HI_W-1:0]   base_hi;
    logic [EVQ_WORD_W-1:0] base_lo;
    logic [7:0]            prio;
  } evq_desc_t;
endpackage

// File: rtl/evq_src_table.sv
module evq_src_table
  import evq_pkg::*;
#(
  parameter int unsigned N_SRC = 8,
  parameter int unsigned ROW_W = 3,
  parameter int unsigned SRC_W = $clog2(N_SRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [ROW_W-1:0] wr_row,
  input  logic [2:0]       wr_word,
  input  logic [31:0]      wr_data,
  input  logic [ROW_W-1:0] rd_row,
  input  logic [2:0]       rd_word,
  output logic [31:0]      rd_data,
  input  logic [SRC_W-1:0] lk_row,
  output evq_src_t         lk_ent
);
  evq_src_t ents [N_SRC];

  for (genvar r = 0; r < N_SRC; r++) begin : g_row
    evq_src_t ent_q;
    logic     we_ctl;
    logic     we_dat;
    assign we_ctl = wr_en && (wr_row == ROW_W'(r)) && (wr_word == 3'd0);
    assign we_dat = wr_en && (wr_row == ROW_W'(r)) && (wr_word == 3'd1);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q <= '0;
      end else begin
        if (we_ctl) begin
          ent_q.valid  <= wr_data[0];
          ent_q.masked <= wr_data[1];
          ent_q.qsel   <= wr_data[15:8];
        end
        if (we_dat) begin
          ent_q.data <= wr_data[EVQ_DATA_W-1:0];
        end
      end
    end
    assign ents[r] = ent_q;
  end

  always_comb begin
    rd_data = '0;
    if (32'(rd_row) < N_SRC) begin
      case (rd_word)
        3'd0:    rd_data = {16'b0, ents[rd_row[SRC_W-1:0]].qsel, 6'b0,
                            ents[rd_row[SRC_W-1:0]].masked, ents[rd_row[SRC_W-1:0]].valid};
        3'd1:    rd_data = {1'b0, ents[rd_row[SRC_W-1:0]].data};
        default: rd_data = '0;
      endcase
    end
  end

  assign lk_ent = ents[lk_row];
endmodule

// File: rtl/evq_desc_table.sv
module evq_desc_table
  import evq_pkg::*;
#(
  parameter int unsigned N_Q   = 4,
  parameter int unsigned ROW_W = 3,
  parameter int unsigned Q_W   = $clog2(N_Q)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ROW_W-1:0]     wr_row,
  input  logic [2:0]           wr_word,
  input  logic [31:0]          wr_data,
  input  logic [ROW_W-1:0]     rd_row,
  input  logic [2:0]           rd_word,
  output logic [31:0]          rd_data,
  input  logic [Q_W-1:0]       lk_q,
  output evq_desc_t            lk_desc,
  input  logic                 upd_en,
  input  logic [Q_W-1:0]       upd_q,
  input  logic [EVQ_IDX_W-1:0] upd_idx,
  input  logic                 upd_gen
);
  evq_desc_t descs [N_Q];

  for (genvar r = 0; r < N_Q; r++) begin : g_row
    evq_desc_t d_q;
    logic      hit;
    logic      we_w0, we_w1, we_w2, we_w3, we_w4, up_here;
    assign hit     = wr_en && (wr_row == ROW_W'(r));
    assign we_w0   = hit && (wr_word == 3'd0);
    assign we_w1   = hit && (wr_word == 3'd1);
    assign we_w2   = hit && (wr_word == 3'd2);
    assign we_w3   = hit && (wr_word == 3'd3);
    assign we_w4   = hit && (wr_word == 3'd4);
    assign up_here = upd_en && (upd_q == Q_W'(r));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        d_q <= '0;
      end else begin
        if (we_w0) begin
          d_q.enq   <= wr_data[0];
          d_q.qsize <= wr_data[7:4];
        end
        if (up_here) begin
          d_q.idx <= upd_idx;
          d_q.gen <= upd_gen;
        end else if (we_w1) begin
          d_q.idx <= wr_data[EVQ_IDX_W-1:0];
          d_q.gen <= wr_data[31];
        end
        if (we_w2) d_q.base_hi <= wr_data[EVQ_HI_W-1:0];
        if (we_w3) d_q.base_lo <= wr_data;
        if (we_w4) d_q.prio    <= wr_data[7:0];
      end
    end
    assign descs[r] = d_q;
  end

  always_comb begin
    rd_data = '0;
    if (32'(rd_row) < N_Q) begin
      case (rd_word)
        3'd0:    rd_data = {24'b0, descs[rd_row[Q_W-1:0]].qsize, 3'b0, descs[rd_row[Q_W-1:0]].enq};
        3'd1:    rd_data = {descs[rd_row[Q_W-1:0]].gen, (31-EVQ_IDX_W)'(0), descs[rd_row[Q_W-1:0]].idx};
        3'd2:    rd_data = {(32-EVQ_HI_W)'(0), descs[rd_row[Q_W-1:0]].base_hi};
        3'd3:    rd_data = descs[rd_row[Q_W-1:0]].base_lo;
        3'd4:    rd_data = {24'b0, descs[rd_row[Q_W-1:0]].prio};
        default: rd_data = '0;
      endcase
    end
  end

  assign lk_desc = descs[lk_q];

  // R9: an update stores the engine's index and flips generation only on a zero index
  a_r9_index_stored: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |=> descs[$past(upd_q)].idx == $past(upd_idx));
  a_r9_gen_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |=> descs[$past(upd_q)].gen ==
               ($past(descs[upd_q].gen) ^ ($past(upd_idx) == '0)));
endmodule

// File: rtl/evq_engine.sv
module evq_engine
  import evq_pkg::*;
#(
  parameter int unsigned N_SRC = 8,
  parameter int unsigned N_Q   = 4,
  parameter int unsigned SRC_W = $clog2(N_SRC),
  parameter int unsigned Q_W   = $clog2(N_Q)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  trig_valid,
  input  logic [SRC_W-1:0]      trig_src,
  output logic                  trig_ready,
  output logic [SRC_W-1:0]      lk_src,
  input  evq_src_t              src_ent,
  output logic [Q_W-1:0]        lk_q,
  input  evq_desc_t             desc,
  output logic                  mem_req_valid,
  input  logic                  mem_req_ready,
  output logic [EVQ_ADDR_W-1:0] mem_addr,
  output logic [31:0]           mem_wdata,
  input  logic                  mem_rsp_valid,
  input  logic                  mem_rsp_err,
  output logic                  upd_en,
  output logic [Q_W-1:0]        upd_q,
  output logic [EVQ_IDX_W-1:0]  upd_idx,
  output logic                  upd_gen,
  output logic                  err_valid,
  output logic [2:0]            err_code
);
  evq_state_e             state_q, state_d;
  logic [SRC_W-1:0]       src_q;
  logic [Q_W-1:0]         q_q;
  logic [EVQ_DATA_W-1:0]  data_q;
  logic [EVQ_ADDR_W-1:0]  addr_q, addr_d;
  logic [31:0]            word_q, word_d;
  logic [EVQ_IDX_W-1:0]   nidx_q, nidx_d, idx_mask, idx_inc;
  logic                   ngen_q, ngen_d;
  logic                   errv_q;
  evq_err_e               errc_q, err_d;
  logic                   err_set;
  logic                   ld_src, ld_ent, ld_wr;
  logic [EVQ_IDX_W:0]     span;

  // Entry arithmetic from the looked-up descriptor
  always_comb begin
    span     = (EVQ_IDX_W+1)'(1) << ({1'b0, desc.qsize} + 5'(EVQ_QSZ_BIAS));
    idx_mask = EVQ_IDX_W'(span - (EVQ_IDX_W+1)'(1));
    idx_inc  = desc.idx + EVQ_IDX_W'(1);
    nidx_d   = idx_inc & idx_mask;
    ngen_d   = desc.gen ^ (nidx_d == '0);
    addr_d   = {desc.base_hi, desc.base_lo} + EVQ_ADDR_W'({desc.idx, 2'b00});
    word_d   = {desc.gen, data_q};
  end

  // Next-state logic
  always_comb begin
    state_d = state_q;
    err_set = 1'b0;
    err_d   = EVQ_ERR_NONE;
    ld_src  = 1'b0;
    ld_ent  = 1'b0;
    ld_wr   = 1'b0;
    upd_en  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (trig_valid) begin
          ld_src  = 1'b1;
          state_d = ST_SRC;
        end
      end
      ST_SRC: begin
        if (!src_ent.valid) begin
          err_set = 1'b1;
          err_d   = EVQ_ERR_BAD_SRC;
          state_d = ST_IDLE;
        end else if (src_ent.masked) begin
          state_d = ST_IDLE;
        end else if (32'(src_ent.qsel) >= N_Q) begin
          err_set = 1'b1;
          err_d   = EVQ_ERR_BAD_QUEUE;
          state_d = ST_IDLE;
        end else begin
          ld_ent  = 1'b1;
          state_d = ST_DESC;
        end
      end
      ST_DESC: begin
        if (desc.prio == EVQ_PRIO_OFF) begin
          err_set = 1'b1;
          err_d   = EVQ_ERR_QUEUE_OFF;
          state_d = ST_IDLE;
        end else if (!desc.enq) begin
          state_d = ST_IDLE;
        end else begin
          ld_wr   = 1'b1;
          state_d = ST_REQ;
        end
      end
      ST_REQ: begin
        if (mem_req_ready) state_d = ST_RSP;
      end
      ST_RSP: begin
        if (mem_rsp_valid) begin
          if (mem_rsp_err) begin
            err_set = 1'b1;
            err_d   = EVQ_ERR_WRITE;
          end else begin
            upd_en = 1'b1;
          end
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      src_q   <= '0;
      q_q     <= '0;
      data_q  <= '0;
      addr_q  <= '0;
      word_q  <= '0;
      nidx_q  <= '0;
      ngen_q  <= 1'b0;
      errv_q  <= 1'b0;
      errc_q  <= EVQ_ERR_NONE;
    end else begin
      state_q <= state_d;
      errv_q  <= err_set;
      if (err_set) errc_q <= err_d;
      if (ld_src)  src_q  <= trig_src;
      if (ld_ent) begin
        q_q    <= src_ent.qsel[Q_W-1:0];
        data_q <= src_ent.data;
      end
      if (ld_wr) begin
        addr_q <= addr_d;
        word_q <= word_d;
        nidx_q <= nidx_d;
        ngen_q <= ngen_d;
      end
    end
  end

  assign trig_ready    = (state_q == ST_IDLE);
  assign mem_req_valid = (state_q == ST_REQ);
  assign mem_addr      = addr_q;
  assign mem_wdata     = {word_q[7:0], word_q[15:8], word_q[23:16], word_q[31:24]};
  assign lk_src        = src_q;
  assign lk_q          = q_q;
  assign upd_q         = q_q;
  assign upd_idx       = nidx_q;
  assign upd_gen       = ngen_q;
  assign err_valid     = errv_q;
  assign err_code      = errc_q;

  // R11: a pending request and its payload hold until accepted
  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_addr) && $stable(mem_wdata)));
  // R11: no new trigger is taken while a request is outstanding
  a_r11_busy_while_req: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !trig_ready);
  // R5: a switched-off queue never produces a request
  a_r5_off_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DESC && desc.prio == EVQ_PRIO_OFF) |=> !mem_req_valid);
  // R10: a failed response is reported and does not update the descriptor
  a_r10_fail_report: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RSP && mem_rsp_valid && mem_rsp_err) |->
      (!upd_en ##1 (err_valid && err_code == 3'd4)));
  // R2: an error pulse never coincides with a request
  a_r2_err_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({err_valid, mem_req_valid}));
endmodule

// File: rtl/evq_writer.sv
module evq_writer
  import evq_pkg::*;
#(
  parameter int unsigned N_SRC = 8,
  parameter int unsigned N_Q   = 4,
  parameter int unsigned SRC_W = $clog2(N_SRC),
  parameter int unsigned Q_W   = $clog2(N_Q),
  parameter int unsigned ROW_W = (SRC_W > Q_W) ? SRC_W : Q_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  trig_valid,
  input  logic [SRC_W-1:0]      trig_src,
  output logic                  trig_ready,
  input  logic                  cfg_wr,
  input  logic                  cfg_tbl,
  input  logic [ROW_W-1:0]      cfg_row,
  input  logic [2:0]            cfg_word,
  input  logic [31:0]           cfg_wdata,
  output logic [31:0]           cfg_rdata,
  output logic                  mem_req_valid,
  input  logic                  mem_req_ready,
  output logic [EVQ_ADDR_W-1:0] mem_addr,
  output logic [31:0]           mem_wdata,
  input  logic                  mem_rsp_valid,
  input  logic                  mem_rsp_err,
  output logic                  err_valid,
  output logic [2:0]            err_code
);
  logic [SRC_W-1:0]     lk_src;
  evq_src_t             src_ent;
  logic [Q_W-1:0]       lk_q;
  evq_desc_t            desc;
  logic                 upd_en;
  logic [Q_W-1:0]       upd_q;
  logic [EVQ_IDX_W-1:0] upd_idx;
  logic                 upd_gen;
  logic [31:0]          src_rdata, desc_rdata;

  evq_src_table #(.N_SRC(N_SRC), .ROW_W(ROW_W), .SRC_W(SRC_W)) u_src (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr && !cfg_tbl),
    .wr_row  (cfg_row),
    .wr_word (cfg_word),
    .wr_data (cfg_wdata),
    .rd_row  (cfg_row),
    .rd_word (cfg_word),
    .rd_data (src_rdata),
    .lk_row  (lk_src),
    .lk_ent  (src_ent)
  );

  evq_desc_table #(.N_Q(N_Q), .ROW_W(ROW_W), .Q_W(Q_W)) u_desc (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr && cfg_tbl),
    .wr_row  (cfg_row),
    .wr_word (cfg_word),
    .wr_data (cfg_wdata),
    .rd_row  (cfg_row),
    .rd_word (cfg_word),
    .rd_data (desc_rdata),
    .lk_q    (lk_q),
    .lk_desc (desc),
    .upd_en  (upd_en),
    .upd_q   (upd_q),
    .upd_idx (upd_idx),
    .upd_gen (upd_gen)
  );

  evq_engine #(.N_SRC(N_SRC), .N_Q(N_Q), .SRC_W(SRC_W), .Q_W(Q_W)) u_eng (
    .clk           (clk),
    .rst_n         (rst_n),
    .trig_valid    (trig_valid),
    .trig_src      (trig_src),
    .trig_ready    (trig_ready),
    .lk_src        (lk_src),
    .src_ent       (src_ent),
    .lk_q          (lk_q),
    .desc          (desc),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_addr      (mem_addr),
    .mem_wdata     (mem_wdata),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_err   (mem_rsp_err),
    .upd_en        (upd_en),
    .upd_q         (upd_q),
    .upd_idx       (upd_idx),
    .upd_gen       (upd_gen),
    .err_valid     (err_valid),
    .err_code      (err_code)
  );

  assign cfg_rdata = cfg_tbl ? desc_rdata : src_rdata;
endmodule

// File: tb/evq_writer_bench.sv
module evq_writer_bench;
  localparam int N_SRC = 8;
  localparam int N_Q   = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        trig_valid;
  logic [2:0]  trig_src;
  logic        trig_ready;
  logic        cfg_wr, cfg_tbl;
  logic [2:0]  cfg_row, cfg_word;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic        mem_req_valid, mem_req_ready;
  logic [59:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_rsp_valid, mem_rsp_err;
  logic        err_valid;
  logic [2:0]  err_code;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  logic [59:0] m_base [N_Q];
  logic [21:0] m_idx  [N_Q];
  logic        m_gen  [N_Q];
  int          m_qsz  [N_Q];

  always #5 clk = ~clk;

  evq_writer #(.N_SRC(N_SRC), .N_Q(N_Q)) u_evq_writer (
    .clk(clk), .rst_n(rst_n), .trig_valid(trig_valid), .trig_src(trig_src),
    .trig_ready(trig_ready), .cfg_wr(cfg_wr), .cfg_tbl(cfg_tbl), .cfg_row(cfg_row),
    .cfg_word(cfg_word), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_err(mem_rsp_err),
    .err_valid(err_valid), .err_code(err_code)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(input bit tbl, input int row, input int word, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_tbl = tbl; cfg_row = 3'(row); cfg_word = 3'(word); cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic cfg_read(input bit tbl, input int row, input int word, output logic [31:0] d);
    @(negedge clk);
    cfg_tbl = tbl; cfg_row = 3'(row); cfg_word = 3'(word);
    #1 d = cfg_rdata;
  endtask

  task automatic set_src(input int s, input bit v, input bit m, input logic [7:0] q, input logic [31:0] d);
    cfg_write(1'b0, s, 0, {16'b0, q, 6'b0, m, v});
    cfg_write(1'b0, s, 1, d);
  endtask

  task automatic set_desc(input int q, input bit enq, input int qsz, input logic [21:0] idx,
                          input bit gen, input logic [59:0] base, input logic [7:0] prio);
    cfg_write(1'b1, q, 0, {24'b0, 4'(qsz), 3'b0, enq});
    cfg_write(1'b1, q, 1, {gen, 9'b0, idx});
    cfg_write(1'b1, q, 2, {4'b0, base[59:32]});
    cfg_write(1'b1, q, 3, base[31:0]);
    cfg_write(1'b1, q, 4, {24'b0, prio});
    m_base[q] = base; m_idx[q] = idx; m_gen[q] = gen; m_qsz[q] = qsz;
  endtask

  // Fire one trigger and act as the memory; observe everything at negedges.
  task automatic fire(input int s, input bit rerr, input int rdly,
                      output bit wrote, output logic [59:0] a, output logic [31:0] w,
                      output int nerr, output logic [2:0] code,
                      output bit busy_ok, output bit hold_ok);
    int phase = 0;
    int waited = 0;
    @(negedge clk);
    trig_valid = 1'b1; trig_src = 3'(s);
    @(negedge clk);
    trig_valid = 1'b0;
    busy_ok = (trig_ready == 1'b0);
    wrote = 0; nerr = 0; hold_ok = 1; code = 3'd0; a = '0; w = '0;
    for (int k = 0; k < 16; k++) begin
      if (err_valid) begin nerr++; code = err_code; end
      case (phase)
        0: if (mem_req_valid) begin
             if (!wrote) begin wrote = 1; a = mem_addr; w = mem_wdata; end
             else if (mem_addr !== a || mem_wdata !== w) hold_ok = 0;
             if (waited == rdly) begin mem_req_ready = 1'b1; phase = 1; end
             else waited++;
           end
        1: begin mem_req_ready = 1'b0; mem_rsp_valid = 1'b1; mem_rsp_err = rerr; phase = 2; end
        2: begin mem_rsp_valid = 1'b0; mem_rsp_err = 1'b0; phase = 3; end
        default: ;
      endcase
      @(negedge clk);
    end
  endtask

  function automatic logic [31:0] unswap(input logic [31:0] b);
    return {b[7:0], b[15:8], b[23:16], b[31:24]};
  endfunction

  // A write expected to reach memory on queue q with payload d.
  task automatic expect_write(input int s, input int q, input logic [30:0] d,
                              input int rdly, input bit rerr);
    bit wrote, busy_ok, hold_ok; logic [59:0] a; logic [31:0] w; int nerr;
    logic [2:0] code; logic [31:0] rb; logic [59:0] ea; longint ent; logic [21:0] ni;
    logic ng;
    ea = m_base[q] + {36'b0, m_idx[q], 2'b00};
    fire(s, rerr, rdly, wrote, a, w, nerr, code, busy_ok, hold_ok);
    check(wrote == 1, "R7", "request issued", wrote, 1);
    check(a == ea, "R7", "address", a, ea);
    check(unswap(w) == {m_gen[q], d}, "R8", "event word", unswap(w), {m_gen[q], d});
    check(busy_ok, "R11", "ready low while busy", busy_ok, 1);
    if (rdly > 0) check(hold_ok, "R11", "request held", hold_ok, 1);
    if (rerr) begin
      check(nerr == 1 && code == 3'd4, "R10", "write fail code", code, 4);
    end else begin
      check(nerr == 0, "R9", "no error on success", nerr, 0);
      ent = (m_qsz[q] + 10 >= 22) ? (64'd1 << 22) : (64'd1 << (m_qsz[q] + 10));
      ni  = 22'((longint'(m_idx[q]) + 1) % ent);
      ng  = m_gen[q] ^ (ni == 0);
      m_idx[q] = ni; m_gen[q] = ng;
    end
    cfg_read(1'b1, q, 1, rb);
    check(rb == {m_gen[q], 9'b0, m_idx[q]}, rerr ? "R10" : "R9", "index/generation",
          rb, {m_gen[q], 9'b0, m_idx[q]});
  endtask

  // A trigger expected to make no write; exp_code 0 means no error pulse.
  task automatic expect_drop(input int s, input int q, input int exp_code, input string req);
    bit wrote, busy_ok, hold_ok; logic [59:0] a; logic [31:0] w; int nerr;
    logic [2:0] code; logic [31:0] rb;
    fire(s, 1'b0, 0, wrote, a, w, nerr, code, busy_ok, hold_ok);
    check(wrote == 0, req, "no memory request", wrote, 0);
    if (exp_code == 0) check(nerr == 0, req, "no error pulse", nerr, 0);
    else check(nerr == 1 && code == 3'(exp_code), req, "error code", code, exp_code);
    check(trig_ready == 1, req, "back to idle", trig_ready, 1);
    if (q >= 0) begin
      cfg_read(1'b1, q, 1, rb);
      check(rb == {m_gen[q], 9'b0, m_idx[q]}, req, "queue state unchanged",
            rb, {m_gen[q], 9'b0, m_idx[q]});
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] rb;
    rst_n = 1'b0; trig_valid = 0; trig_src = 0; cfg_wr = 0; cfg_tbl = 0; cfg_row = 0;
    cfg_word = 0; cfg_wdata = 0; mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_err = 0;
    for (int q = 0; q < N_Q; q++) begin m_base[q] = '0; m_idx[q] = '0; m_gen[q] = 0; m_qsz[q] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check(trig_ready == 1, "R1", "trig_ready", trig_ready, 1);
    check(mem_req_valid == 0, "R1", "mem_req_valid", mem_req_valid, 0);
    check(err_valid == 0, "R1", "err_valid", err_valid, 0);
    for (int q = 0; q < N_Q; q++) begin
      for (int wd = 0; wd < 5; wd++) begin
        cfg_read(1'b1, q, wd, rb);
        check(rb == 0, "R1", "descriptor word after reset", rb, 0);
      end
    end
    for (int s = 0; s < N_SRC; s++) begin
      cfg_read(1'b0, s, 0, rb);
      check(rb == 0, "R1", "source word after reset", rb, 0);
    end

    // R2: every source is invalid after reset
    for (int s = 0; s < N_SRC; s++) expect_drop(s, -1, 1, "R2");

    // R7 R8 R9 R11: sweep more than a full lap of a 1024-entry queue, base crosses bit 32
    set_desc(0, 1, 0, 22'd0, 1'b0, 60'hABCDEF0_FFFFFF00, 8'h05);
    for (int i = 0; i < 1030; i++) begin
      logic [31:0] d;
      d = 32'h8000_0000 | (i * 32'h0001_0003) | 32'h4000_0000;
      set_src(0, 1, 0, 8'd0, d);
      expect_write(0, 0, d[30:0], i % 3, 1'b0);
    end

    // R9: qsize 1 wraps at 2048 and flips generation 1 -> 0
    set_desc(1, 1, 1, 22'd2046, 1'b1, 60'h0000001_00000000, 8'h00);
    set_src(1, 1, 0, 8'd1, 32'h1234_5678);
    for (int i = 0; i < 3; i++) expect_write(1, 1, 31'h1234_5678, 0, 1'b0);
    set_desc(1, 1, 1, 22'd1023, 1'b0, 60'h0000001_00000000, 8'h00);
    expect_write(1, 1, 31'h1234_5678, 0, 1'b0);
    // R9: largest qsize wraps at the 22-bit index limit
    set_desc(2, 1, 15, 22'h3FFFFF, 1'b0, 60'h0000000_00000123, 8'h10);
    set_src(6, 1, 0, 8'd2, 32'h0000_00AA);
    expect_write(6, 2, 31'h0000_00AA, 1, 1'b0);

    // R3: masked source is dropped silently
    set_src(2, 1, 1, 8'd1, 32'h5555_5555);
    expect_drop(2, 1, 0, "R3");
    // R2: invalid source reports code 1 even when its mask bit is set
    set_src(3, 0, 1, 8'd1, 32'h0);
    expect_drop(3, 1, 1, "R2");
    // R4: queue selectors at and above N_Q
    set_src(4, 1, 0, 8'd4, 32'h1);
    expect_drop(4, -1, 2, "R4");
    set_src(4, 1, 0, 8'd200, 32'h1);
    expect_drop(4, -1, 2, "R4");

    // R5: priority 0xFF switches the queue off; 0xFE does not
    set_desc(3, 1, 0, 22'd7, 1'b1, 60'h0000002_00001000, 8'hFF);
    set_src(5, 1, 0, 8'd3, 32'h0BAD_F00D);
    expect_drop(5, 3, 3, "R5");
    cfg_write(1'b1, 3, 4, 32'h0000_00FE);
    expect_write(5, 3, 31'h0BAD_F00D, 0, 1'b0);
    // R6: enqueue disabled
    cfg_write(1'b1, 3, 0, 32'h0000_0000);
    cfg_write(1'b1, 3, 4, 32'h0000_0000);
    expect_drop(5, 3, 0, "R6");

    // R10: failed write keeps the slot; the retry goes to the same address
    set_src(0, 1, 0, 8'd0, 32'h0000_0777);
    expect_write(0, 0, 31'h0000_0777, 2, 1'b1);
    expect_write(0, 0, 31'h0000_0777, 0, 1'b0);

    summary();
    $finish;
  end
endmodule